// File: doc/BRIEF.md
# Parallel Port Controller with Command/Status

This block gives a processor bus access to three parallel ports: two 8-bit ports and one 6-bit port that can serve as plain I/O or as handshake lines for the two wide ports. The processor reaches it over an 8-bit multiplexed address/data bus. While the address strobe is high, the low three bus bits, the chip select and the I/O select are captured. A later read or write pulse then acts on the register those captured bits select. The upper five address bits are ignored.

One register address has two meanings. A write there loads a command byte. The command sets the direction of each wide port, the role of the narrow port, the two interrupt enables, and a two-bit timer command. That command goes out to an external timer together with a one-cycle load pulse. A read of the same address returns a status byte instead. The status byte holds per-port request, buffer-full and enable flags, plus a flag that latches the external timer's terminal-count pulse.

In the handshake roles, an active-low strobe on a narrow-port pin controls the exchange. On an input port the strobe latches incoming data. On an output port the strobe acknowledges data already written. The request and buffer-full flags are driven onto neighbouring narrow-port pins.

Top module: `pio_cmdstat`

## Requirements
- R1: Only address bits 2:0 select a register (000 command/status, 001 wide port A, 010 wide port B, 011 narrow port C). Bits 7:3 have no effect.
- R2: A read or write acts only if chip select and I/O select were both high when the address strobe was last high. Otherwise writes change nothing and `adOe` stays low.
- R3: A write to 000 loads the command byte, and a read of 000 returns the status byte {0, timer, enB, fullB, reqB, enA, fullA, reqA} (bit 7 down to bit 0). The command byte is never returned.
- R4: Command bit 0 (port A) and bit 1 (port B) set direction, 1 = output. An output port drives its written value and reads it back. An input port reads its pins and ignores writes to its value.
- R5: Command bits 3:2 set the role of port C. 00: all six pins are inputs. 11: all six are outputs. 01: pins 0/1 drive port A request/full, pin 2 is the port A strobe input, and pins 5:3 are outputs. 10: the same as 01 for pins 2:0, pins 3/4 drive port B request/full, and pin 5 is the port B strobe input.
- R6: A port C read returns, per bit, the driven value for an output pin and the pin level for an input pin. Bits 7:6 read as zero.
- R7: On a handshaked input port, the strobe falling latches the pins and sets full. The strobe rising sets request if that port's enable is set. The start of a read of that port clears request, and the end of the read clears full. The read returns the latched value.
- R8: On a handshaked output port, a write sets full and clears request. The strobe falling clears full, and the strobe rising sets request if that port's enable is set.
- R9: Command bit 4 enables port A requests and bit 5 enables port B requests. Each enable is reported in the status byte. With an enable clear, that port's request never sets.
- R10: A terminal-count pulse sets the timer flag. The end of a status read clears it, except that a pulse in the same cycle keeps it set.
- R11: Command bits 7:6 appear on `timerCmd`. `timerLoad` is high for exactly one cycle after each command write.
- R12: After reset the command byte is zero: all ports are inputs, all flags are clear, and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobe | input | 1 | Address strobe; bus address is captured while high |
| chipSel | input | 1 | Chip select, captured with the address |
| ioSel | input | 1 | High selects the register space, captured with the address |
| rdEn | input | 1 | Read pulse, active high |
| wrEn | input | 1 | Write pulse, active high |
| adIn | input | 8 | Multiplexed address/data bus, inbound |
| adOut | output | 8 | Read data |
| adOe | output | 1 | Read data enable |
| paIn | input | 8 | Port A pin levels |
| paOut | output | 8 | Port A output value |
| paOe | output | 1 | Port A drives its pins |
| pbIn | input | 8 | Port B pin levels |
| pbOut | output | 8 | Port B output value |
| pbOe | output | 1 | Port B drives its pins |
| pcIn | input | 6 | Port C pin levels |
| pcOut | output | 6 | Port C output values |
| pcOe | output | 6 | Port C per-pin drive enable |
| tcPulse | input | 1 | Terminal-count pulse from the external timer |
| timerCmd | output | 2 | Timer command field of the command byte |
| timerLoad | output | 1 | One-cycle pulse after a command write |

## Verification
A table of vectors covers each direction combination for the wide ports, each of the four port C roles, a write-only value on an input port, and aliased upper address bits. Together these separate the direction decode from the read path and catch mode-field swaps. Directed sequences then walk a full input handshake and a full output handshake, both with the request enable set and with it clear. This tells a correct request gate apart from one that ignores the enable. Further sequences cover deselected accesses, the timer flag with a pulse that collides with the clearing read, and the reset state.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W = 8;
  localparam int PC_W  = 6;
  localparam int SEL_W = 3;
  localparam int NPORT = 2;

  localparam logic [SEL_W-1:0] SEL_CS = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PA = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PB = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PC = 3'd3;

  typedef enum logic [1:0] {
    PC_ALL_IN  = 2'b00,
    PC_HS_A    = 2'b01,
    PC_HS_AB   = 2'b10,
    PC_ALL_OUT = 2'b11
  } pcMode_e;

  typedef struct packed {
    logic [1:0] timerCmd;
    logic       ieB;
    logic       ieA;
    pcMode_e    pcMode;
    logic       dirB;
    logic       dirA;
  } cmd_t;

  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             wrC;
    logic             capA;
    logic             capB;
    logic [BUS_W-1:0] wdata;
  } strobe_t;

  typedef struct packed {
    logic intrB;
    logic bfB;
    logic intrA;
    logic bfA;
  } flags_t;
endpackage

// File: rtl/pio_handshake.sv
module pio_handshake (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic isOutput,
  input  logic intEn,
  input  logic strobeN,
  input  logic readStart,
  input  logic readEnd,
  input  logic writeDone,
  output logic intr,
  output logic bufFull,
  output logic capture
);
  logic strobePrev;
  logic fallEdge;
  logic riseEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= strobeN;
  end

  assign fallEdge = enable & strobePrev & ~strobeN;
  assign riseEdge = enable & ~strobePrev & strobeN;
  assign capture  = fallEdge & ~isOutput;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intr    <= 1'b0;
      bufFull <= 1'b0;
    end else if (!enable) begin
      intr    <= 1'b0;
      bufFull <= 1'b0;
    end else if (isOutput) begin
      if (writeDone) begin
        bufFull <= 1'b1;
        intr    <= 1'b0;
      end else begin
        if (fallEdge)         bufFull <= 1'b0;
        if (riseEdge && intEn) intr   <= 1'b1;
      end
    end else begin
      if (fallEdge)          bufFull <= 1'b1;
      if (riseEdge && intEn) intr    <= 1'b1;
      if (readStart)         intr    <= 1'b0;
      if (readEnd)           bufFull <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_control.sv
module pio_control
  import pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrStrobe,
  input  logic                 chipSel,
  input  logic                 ioSel,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [BUS_W-1:0]     adIn,
  input  logic [NPORT-1:0]     stbN,
  input  logic                 tcPulse,
  output cmd_t                 cmd,
  output strobe_t              strb,
  output flags_t               flags,
  output logic                 timerFlag,
  output logic [SEL_W-1:0]     selAddr,
  output logic                 accessOk,
  output logic                 timerLoad
);
  logic csQ, ioQ, wrPrev, rdPrev;
  logic wrRise, rdStart, rdEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAddr <= '0;
      csQ     <= 1'b0;
      ioQ     <= 1'b0;
    end else if (addrStrobe) begin
      selAddr <= adIn[SEL_W-1:0];
      csQ     <= chipSel;
      ioQ     <= ioSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrEn;
      rdPrev <= rdEn;
    end
  end

  assign accessOk = csQ & ioQ;
  assign wrRise   = accessOk & wrEn & ~wrPrev;
  assign rdStart  = accessOk & rdEn & ~rdPrev;
  assign rdEnd    = accessOk & ~rdEn & rdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd       <= '0;
      timerLoad <= 1'b0;
    end else begin
      timerLoad <= wrRise && (selAddr == SEL_CS);
      if (wrRise && (selAddr == SEL_CS)) cmd <= cmd_t'(adIn);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                timerFlag <= 1'b0;
    else if (tcPulse)                         timerFlag <= 1'b1;
    else if (rdEnd && (selAddr == SEL_CS))    timerFlag <= 1'b0;
  end

  logic [NPORT-1:0] hsEn, hsDir, hsIe, hsIntr, hsBf, hsCap;

  always_comb begin
    hsEn[0]  = (cmd.pcMode == PC_HS_A) || (cmd.pcMode == PC_HS_AB);
    hsEn[1]  = (cmd.pcMode == PC_HS_AB);
    hsDir[0] = cmd.dirA;
    hsDir[1] = cmd.dirB;
    hsIe[0]  = cmd.ieA;
    hsIe[1]  = cmd.ieB;
  end

  for (genvar p = 0; p < NPORT; p++) begin : gHs
    localparam logic [SEL_W-1:0] PSEL = SEL_W'(p + 1);
    pio_handshake uHs (
      .clk       (clk),
      .rstN      (rstN),
      .enable    (hsEn[p]),
      .isOutput  (hsDir[p]),
      .intEn     (hsIe[p]),
      .strobeN   (stbN[p]),
      .readStart (rdStart && (selAddr == PSEL)),
      .readEnd   (rdEnd && (selAddr == PSEL)),
      .writeDone (wrRise && (selAddr == PSEL)),
      .intr      (hsIntr[p]),
      .bufFull   (hsBf[p]),
      .capture   (hsCap[p])
    );
  end

  always_comb begin
    strb.wrA   = wrRise && (selAddr == SEL_PA);
    strb.wrB   = wrRise && (selAddr == SEL_PB);
    strb.wrC   = wrRise && (selAddr == SEL_PC);
    strb.capA  = hsCap[0];
    strb.capB  = hsCap[1];
    strb.wdata = adIn;
    flags.intrA = hsIntr[0];
    flags.bfA   = hsBf[0];
    flags.intrB = hsIntr[1];
    flags.bfB   = hsBf[1];
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirA,
  input  logic             dirB,
  input  logic             ieA,
  input  logic             ieB,
  input  pcMode_e          pcMode,
  input  strobe_t          strb,
  input  flags_t           flags,
  input  logic             timerFlag,
  input  logic [SEL_W-1:0] selAddr,
  input  logic [BUS_W-1:0] paIn,
  input  logic [BUS_W-1:0] pbIn,
  input  logic [PC_W-1:0]  pcIn,
  output logic [BUS_W-1:0] paOut,
  output logic [BUS_W-1:0] pbOut,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  pcOe,
  output logic [BUS_W-1:0] rdData
);
  logic [BUS_W-1:0] outA, outB, latA, latB;
  logic [PC_W-1:0]  pcReg, pcView;
  logic [BUS_W-1:0] viewA, viewB;
  logic             hsA, hsB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA  <= '0;
      outB  <= '0;
      latA  <= '0;
      latB  <= '0;
      pcReg <= '0;
    end else begin
      if (strb.wrA)  outA  <= strb.wdata;
      if (strb.wrB)  outB  <= strb.wdata;
      if (strb.wrC)  pcReg <= strb.wdata[PC_W-1:0];
      if (strb.capA) latA  <= paIn;
      if (strb.capB) latB  <= pbIn;
    end
  end

  assign hsA = (pcMode == PC_HS_A) || (pcMode == PC_HS_AB);
  assign hsB = (pcMode == PC_HS_AB);

  always_comb begin
    pcOe  = '0;
    pcOut = pcReg;
    unique case (pcMode)
      PC_ALL_IN:  pcOe = '0;
      PC_ALL_OUT: pcOe = '1;
      PC_HS_A: begin
        pcOe       = 6'b111011;
        pcOut[1:0] = {flags.bfA, flags.intrA};
      end
      PC_HS_AB: begin
        pcOe       = 6'b011011;
        pcOut[4:3] = {flags.bfB, flags.intrB};
        pcOut[1:0] = {flags.bfA, flags.intrA};
      end
      default: pcOe = '0;
    endcase
  end

  assign pcView = (pcOut & pcOe) | (pcIn & ~pcOe);
  assign viewA  = dirA ? outA : (hsA ? latA : paIn);
  assign viewB  = dirB ? outB : (hsB ? latB : pbIn);
  assign paOut  = outA;
  assign pbOut  = outB;

  always_comb begin
    unique case (selAddr)
      SEL_CS:  rdData = {1'b0, timerFlag, ieB, flags.bfB, flags.intrB,
                         ieA, flags.bfA, flags.intrA};
      SEL_PA:  rdData = viewA;
      SEL_PB:  rdData = viewB;
      SEL_PC:  rdData = {{(BUS_W-PC_W){1'b0}}, pcView};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pio_cmdstat.sv
module pio_cmdstat
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrStrobe,
  input  logic             chipSel,
  input  logic             ioSel,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] adIn,
  output logic [BUS_W-1:0] adOut,
  output logic             adOe,
  input  logic [BUS_W-1:0] paIn,
  output logic [BUS_W-1:0] paOut,
  output logic             paOe,
  input  logic [BUS_W-1:0] pbIn,
  output logic [BUS_W-1:0] pbOut,
  output logic             pbOe,
  input  logic [PC_W-1:0]  pcIn,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  pcOe,
  input  logic             tcPulse,
  output logic [1:0]       timerCmd,
  output logic             timerLoad
);
  cmd_t             cmd;
  strobe_t          strb;
  flags_t           flags;
  logic             timerFlag;
  logic [SEL_W-1:0] selAddr;
  logic             accessOk;

  pio_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrStrobe (addrStrobe),
    .chipSel    (chipSel),
    .ioSel      (ioSel),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .adIn       (adIn),
    .stbN       ({pcIn[5], pcIn[2]}),
    .tcPulse    (tcPulse),
    .cmd        (cmd),
    .strb       (strb),
    .flags      (flags),
    .timerFlag  (timerFlag),
    .selAddr    (selAddr),
    .accessOk   (accessOk),
    .timerLoad  (timerLoad)
  );

  pio_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .dirA      (cmd.dirA),
    .dirB      (cmd.dirB),
    .ieA       (cmd.ieA),
    .ieB       (cmd.ieB),
    .pcMode    (cmd.pcMode),
    .strb      (strb),
    .flags     (flags),
    .timerFlag (timerFlag),
    .selAddr   (selAddr),
    .paIn      (paIn),
    .pbIn      (pbIn),
    .pcIn      (pcIn),
    .paOut     (paOut),
    .pbOut     (pbOut),
    .pcOut     (pcOut),
    .pcOe      (pcOe),
    .rdData    (adOut)
  );

  assign adOe     = rdEn & accessOk;
  assign paOe     = cmd.dirA;
  assign pbOe     = cmd.dirB;
  assign timerCmd = cmd.timerCmd;
endmodule

// File: rtl/pio_cmdstat_chk.sv
module pio_cmdstat_chk
  import pio_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             rdEn,
  input logic             adOe,
  input logic [BUS_W-1:0] adOut,
  input logic [SEL_W-1:0] selAddr,
  input logic             tcPulse,
  input logic             timerFlag,
  input logic [PC_W-1:0]  pcOe,
  input cmd_t             cmd,
  input flags_t           flags,
  input logic             timerLoad
);
  logic hsOff;
  assign hsOff = (cmd.pcMode == PC_ALL_IN) || (cmd.pcMode == PC_ALL_OUT);

  // R2
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> rdEn);

  // R3
  status_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && selAddr == SEL_CS) |-> !adOut[7]);

  // R10
  timer_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |=> timerFlag);

  // R5
  pc_oe_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcOe == 6'b000000) || (pcOe == 6'b111111) ||
    (pcOe == 6'b111011) || (pcOe == 6'b011011));

  // R7
  hs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsOff && $past(hsOff)) |-> (flags == '0));

  // R11
  load_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerLoad |=> !timerLoad);
endmodule

bind pio_cmdstat pio_cmdstat_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .adOe      (adOe),
  .adOut     (adOut),
  .selAddr   (selAddr),
  .tcPulse   (tcPulse),
  .timerFlag (timerFlag),
  .pcOe      (pcOe),
  .cmd       (cmd),
  .flags     (flags),
  .timerLoad (timerLoad)
);

// File: tb/pio_cmdstat_test.sv
module pio_cmdstat_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrStrobe = 1'b0, chipSel = 1'b0, ioSel = 1'b0;
  logic       rdEn = 1'b0, wrEn = 1'b0, tcPulse = 1'b0;
  logic [7:0] adIn = '0, paIn = '0, pbIn = '0;
  logic [5:0] pcIn = 6'h3F;
  logic [7:0] adOut, paOut, pbOut;
  logic       adOe, paOe, pbOe, timerLoad;
  logic [5:0] pcOut, pcOe;
  logic [1:0] timerCmd;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  logic loadSeen;

  always #4 clk = ~clk;

  pio_cmdstat uut (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .chipSel(chipSel),
    .ioSel(ioSel), .rdEn(rdEn), .wrEn(wrEn), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .paIn(paIn), .paOut(paOut), .paOe(paOe), .pbIn(pbIn),
    .pbOut(pbOut), .pbOe(pbOe), .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe),
    .tcPulse(tcPulse), .timerCmd(timerCmd), .timerLoad(timerLoad)
  );

  // {cmd, wrAddr, wrData, rdAddr, paIn, pbIn, pcIn, expected}
  localparam int NVEC = 10;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h00_01_55_01_A3_00_3F_A3,
    64'h01_01_3C_01_00_00_3F_3C,
    64'h02_02_C3_02_00_11_3F_C3,
    64'h02_01_77_01_9A_00_3F_9A,
    64'h00_03_2A_03_00_00_15_15,
    64'h0C_03_EA_03_00_00_3F_2A,
    64'h04_03_38_03_00_00_3F_3C,
    64'h08_03_3F_03_00_00_24_24,
    64'h03_F9_81_41_00_00_3F_81,
    64'h30_01_00_00_00_00_3F_24
  };

  function automatic string vecTag(input int i);
    if (i < 4)       return "R4";
    else if (i == 4) return "R6";
    else if (i == 5) return "R6";
    else if (i < 8)  return "R5";
    else if (i == 8) return "R1";
    else             return "R9";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d,
                          input logic cs = 1'b1, input logic io = 1'b1);
    @(negedge clk); addrStrobe = 1'b1; adIn = a; chipSel = cs; ioSel = io;
    @(negedge clk); addrStrobe = 1'b0; adIn = d; wrEn = 1'b1;
    @(negedge clk); loadSeen = timerLoad; wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d, output logic oe,
                         input logic cs = 1'b1, input logic io = 1'b1);
    @(negedge clk); addrStrobe = 1'b1; adIn = a; chipSel = cs; ioSel = io;
    @(negedge clk); addrStrobe = 1'b0; adIn = 8'h00; rdEn = 1'b1;
    @(negedge clk); d = adOut; oe = adOe; rdEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12 paOe", {7'b0, paOe}, 8'h00);
    check("R12 pbOe", {7'b0, pbOe}, 8'h00);
    check("R12 pcOe", {2'b0, pcOe}, 8'h00);
    busRead(8'h00, rd, oe);
    check("R12 status", rd, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      paIn = VEC[i][31:24];
      pbIn = VEC[i][23:16];
      pcIn = VEC[i][13:8];
      busWrite(8'h00, VEC[i][63:56]);
      busWrite(VEC[i][55:48], VEC[i][47:40]);
      busRead(VEC[i][39:32], rd, oe);
      check(vecTag(i), rd, VEC[i][7:0]);
    end

    // R2: deselected accesses
    pcIn = 6'h3F;
    busWrite(8'h00, 8'h01);
    busWrite(8'h01, 8'h11);
    busWrite(8'h01, 8'hEE, 1'b0, 1'b1);
    busWrite(8'h01, 8'hEE, 1'b1, 1'b0);
    busRead(8'h01, rd, oe);
    check("R2 write ignored", rd, 8'h11);
    busRead(8'h01, rd, oe, 1'b0, 1'b1);
    check("R2 adOe low", {7'b0, oe}, 8'h00);
    // R4: output drive
    check("R4 paOe", {7'b0, paOe}, 8'h01);
    check("R4 paOut", paOut, 8'h11);

    // R11 / R3: timer command and status separate from command
    busWrite(8'h00, 8'hFF);
    check("R11 timerLoad", {7'b0, loadSeen}, 8'h01);
    check("R11 timerCmd", {6'b0, timerCmd}, 8'h03);
    @(negedge clk);
    check("R11 load ends", {7'b0, timerLoad}, 8'h00);
    busRead(8'h00, rd, oe);
    check("R3 status", rd, 8'h24);

    // R10: timer flag
    busWrite(8'h00, 8'h00);
    @(negedge clk); tcPulse = 1'b1;
    @(negedge clk); tcPulse = 1'b0;
    @(negedge clk); addrStrobe = 1'b1; adIn = 8'h00; chipSel = 1'b1; ioSel = 1'b1;
    @(negedge clk); addrStrobe = 1'b0; rdEn = 1'b1;
    @(negedge clk); rd = adOut; rdEn = 1'b0; tcPulse = 1'b1;
    check("R10 flag set", rd, 8'h40);
    @(negedge clk); tcPulse = 1'b0;
    busRead(8'h00, rd, oe);
    check("R10 set wins over clear", rd, 8'h40);
    busRead(8'h00, rd, oe);
    check("R10 cleared by read", rd, 8'h00);

    // R7: strobed input on port A
    paIn = 8'h5E;
    pcIn = 6'h3F;
    busWrite(8'h00, 8'h14);
    @(negedge clk); pcIn = 6'h3B;
    @(negedge clk); paIn = 8'h00;
    check("R7 full set", {7'b0, pcOut[1]}, 8'h01);
    check("R7 no request yet", {7'b0, pcOut[0]}, 8'h00);
    pcIn = 6'h3F;
    @(negedge clk);
    check("R7 request set", {7'b0, pcOut[0]}, 8'h01);
    busRead(8'h00, rd, oe);
    check("R7 status", rd, 8'h07);
    busRead(8'h01, rd, oe);
    check("R7 latched data", rd, 8'h5E);
    check("R7 flags cleared", {6'b0, pcOut[1:0]}, 8'h00);

    // R8: strobed output on port B
    busWrite(8'h00, 8'h2A);
    busWrite(8'h02, 8'h99);
    check("R8 pbOut", pbOut, 8'h99);
    check("R8 full set", {7'b0, pcOut[4]}, 8'h01);
    @(negedge clk); pcIn = 6'h1F;
    @(negedge clk);
    check("R8 full cleared", {7'b0, pcOut[4]}, 8'h00);
    pcIn = 6'h3F;
    @(negedge clk);
    check("R8 request set", {7'b0, pcOut[3]}, 8'h01);
    busRead(8'h00, rd, oe);
    check("R8 status", rd, 8'h28);

    // R9: enable clear blocks request
    busWrite(8'h00, 8'h0A);
    busWrite(8'h02, 8'h42);
    @(negedge clk); pcIn = 6'h1F;
    @(negedge clk); pcIn = 6'h3F;
    @(negedge clk);
    check("R9 request blocked", {7'b0, pcOut[3]}, 8'h00);
    busRead(8'h00, rd, oe);
    check("R9 status", rd, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule